// File: doc/BRIEF.md
# Burst Address Generator

This block produces the array address for each beat of a four-beat burst inside a synchronous static memory. A burst opens when the block samples a start address from the external address bus. After that, each advance cycle steps the two lowest address bits to the next beat. The upper address bits do not change for the whole burst. Two beat orders are available. Linear order counts up and wraps modulo four. Interleaved order XORs the start offset with a beat count that counts up. Either order can begin at any of the four offsets, and after four beats it returns to the start offset.

All activity is gated by an active-low clock enable. When the enable is inactive, every internal register holds its value. The block is controlled by a small two-state machine:
- **ST_IDLE**: no burst is open.
- **ST_BURST**: a burst is being stepped.

The machine has these transitions:
- **T_LOAD**: ST_IDLE or ST_BURST to ST_BURST, on advance low with select high.
- **T_DESEL**: ST_BURST to ST_IDLE, on advance low with select low.
- **T_STEP**: ST_BURST to ST_BURST, on advance high.
- **T_PARK**: ST_IDLE to ST_IDLE, on advance high or on advance low with select low.
- **T_FREEZE**: any state holds, on clock enable high.

The order input is captured when a burst is loaded. The captured order applies to the whole burst.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `arr_addr` is all zeros and `active` is 0.
- R2: On a rising edge with `cke_n`=0, `adv`=0 and `sel`=1, `arr_addr` becomes the value of `ext_addr` sampled at that edge, and `active` becomes 1. This load starts a new burst at beat count 0.
- R3: With order 0 (linear) captured at load, beat n (n = 0..3) carries the low two bits (start + n) mod 4.
- R4: With order 1 (interleaved) captured at load, beat n carries the low two bits start XOR n.
- R5: After four advances, the low two bits equal the start offset again, and the sequence repeats.
- R6: During advances, bits [ADDR_W-1:2] of `arr_addr` keep the value loaded at the start of the burst.
- R7: While `cke_n`=1, `arr_addr` and `active` do not change, whatever `adv`, `sel`, `ext_addr` and `order_sel` carry.
- R8: On an enabled edge with `adv`=0 and `sel`=0, `active` becomes 0 and `arr_addr` keeps its value.
- R9: On an enabled edge with `adv`=1 while `active`=0, `arr_addr` does not change and `active` stays 0.
- R10: A change of `order_sel` after the load does not alter the order of the open burst. The new level takes effect at the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high freezes all state |
| adv | input | 1 | Low: load or deselect; high: advance to the next beat |
| sel | input | 1 | Load qualifier; high with `adv` low starts a burst |
| ext_addr | input | ADDR_W | External start address |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved |
| arr_addr | output | ADDR_W | Current array address |
| active | output | 1 | High while a burst is open |

## Verification
The assertions take for granted that the controls are driven to known levels on every edge after reset. The linear-step property also assumes that the captured order changes only at a load, so it is checked only on advance cycles.

The stimulus changes `order_sel` only at negative edges. That includes the deliberate mid-burst flips used to exercise R10 and R7. Each sweep step is a single whole cycle of inputs applied at the negative edge, so no input moves near a sampling edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } beat_order_t;

endpackage

// File: rtl/burst_ctrl_fsm.sv
module burst_ctrl_fsm
    import burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cke_n,
    input  logic         adv,
    input  logic         sel,
    output burst_state_t state_o,
    output logic         load_o,
    output logic         step_o
);

    burst_state_t state_q;
    burst_state_t state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!cke_n) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!adv && sel) state_d = ST_BURST;          // T_LOAD
                end
                ST_BURST: begin
                    if (!adv) state_d = sel ? ST_BURST : ST_IDLE; // T_LOAD / T_DESEL
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        if (!cke_n) begin
            unique case (state_q)
                ST_IDLE: begin
                    load_o = !adv && sel;
                end
                ST_BURST: begin
                    load_o = !adv && sel;
                    step_o = adv;                                // T_STEP
                end
                default: begin
                    load_o = 1'b0;
                    step_o = 1'b0;
                end
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [BEAT_W-1:0] start_off,
    input  logic              order_in,
    output logic [BEAT_W-1:0] off_o,
    output beat_order_t       order_q_o
);

    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] cnt_q;
    beat_order_t       order_q;
    logic [BEAT_W-1:0] lin_off;
    logic [BEAT_W-1:0] ilv_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
            order_q <= ORD_LINEAR;
        end else if (load) begin
            start_q <= start_off;
            cnt_q   <= '0;
            order_q <= beat_order_t'(order_in);
        end else if (step) begin
            cnt_q   <= cnt_q + ONE;   // wraps modulo burst length
        end
    end

    assign lin_off = start_q + cnt_q;
    assign ilv_off = start_q ^ cnt_q;

    always_comb begin
        unique case (order_q)
            ORD_LINEAR:     off_o = lin_off;
            ORD_INTERLEAVE: off_o = ilv_off;
            default:        off_o = lin_off;
        endcase
    end

    assign order_q_o = order_q;

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [HI_W-1:0] d,
    output logic [HI_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              adv,
    input  logic              sel,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              active
);

    localparam int HI_W = ADDR_W - BEAT_W;

    burst_state_t      state;
    logic              load;
    logic              step;
    logic [BEAT_W-1:0] off;
    logic [HI_W-1:0]   hi_q;
    beat_order_t       order_q;

    burst_ctrl_fsm u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke_n   (cke_n),
        .adv     (adv),
        .sel     (sel),
        .state_o (state),
        .load_o  (load),
        .step_o  (step)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .start_off (ext_addr[BEAT_W-1:0]),
        .order_in  (order_sel),
        .off_o     (off),
        .order_q_o (order_q)
    );

    burst_base_reg #(.HI_W(HI_W)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (ext_addr[ADDR_W-1:BEAT_W]),
        .q     (hi_q)
    );

    assign arr_addr = {hi_q, off};
    assign active   = (state == ST_BURST);

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              adv,
    input logic              sel,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              active,
    input beat_order_t       order_q
);

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(arr_addr) && $stable(active)));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && sel) |=> (arr_addr == $past(ext_addr) && active));

    assert_upper_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv && active) |=>
            (arr_addr[ADDR_W-1:BEAT_W] == $past(arr_addr[ADDR_W-1:BEAT_W])));

    assert_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && !sel) |=> (!active && $stable(arr_addr)));

    assert_idle_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv && !active) |=> (!active && $stable(arr_addr)));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv && active && order_q == ORD_LINEAR) |=>
            (arr_addr[BEAT_W-1:0] == BEAT_W'($past(arr_addr[BEAT_W-1:0]) + 1'b1)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke_n    (cke_n),
    .adv      (adv),
    .sel      (sel),
    .ext_addr (ext_addr),
    .arr_addr (arr_addr),
    .active   (active),
    .order_q  (order_q)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b1;
    logic          adv = 1'b0;
    logic          sel = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] arr_addr;
    logic          active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .adv       (adv),
        .sel       (sel),
        .ext_addr  (ext_addr),
        .order_sel (order_sel),
        .arr_addr  (arr_addr),
        .active    (active)
    );

    function automatic logic [1:0] beat_off(input logic [1:0] s, input int n, input logic m);
        logic [1:0] nn;
        nn = 2'(n);
        return m ? (s ^ nn) : 2'(s + nn);
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // apply one cycle of inputs at a negedge, return at the next negedge
    task automatic cyc(input logic c, input logic a, input logic s,
                       input logic [AW-1:0] ad, input logic m);
        cke_n = c; adv = a; sel = s; ext_addr = ad; order_sel = m;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        logic [AW-1:0] held;
        repeat (3) @(negedge clk);
        chk("R1 reset addr", arr_addr, '0);
        chk("R1 reset active", AW'(active), '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int h = 0; h < 3; h++) begin
                    logic [AW-3:0] hi;
                    hi = (AW-2)'((m * 97 + s * 41 + h * 73 + 5) % 256);
                    base = {hi, 2'(s)};
                    cyc(1'b0, 1'b0, 1'b1, base, 1'(m));
                    chk("R2 load addr", arr_addr, base);
                    chk("R2 load active", AW'(active), AW'(1));
                    for (int n = 1; n <= 8; n++) begin
                        if (n == 2) begin
                            held = arr_addr;
                            cyc(1'b1, 1'b0, 1'b1, ~base, 1'(~m)); // frozen, R7
                            chk("R7 freeze addr", arr_addr, held);
                            chk("R7 freeze active", AW'(active), AW'(1));
                            order_sel = 1'(~m);                   // R10 flip mid-burst
                        end
                        cyc(1'b0, 1'b1, 1'b0, ~base, order_sel);
                        chk(m ? "R4 interleaved beat" : "R3 linear beat",
                            arr_addr, {hi, beat_off(2'(s), n, 1'(m))});
                        chk("R6 upper held", {arr_addr[AW-1:2], 2'b00}, {hi, 2'b00});
                        if (n == 4)
                            chk("R5 wrap to start", AW'(arr_addr[1:0]), AW'(s));
                        if (n == 3)
                            chk("R10 order kept", arr_addr, {hi, beat_off(2'(s), 3, 1'(m))});
                    end
                    held = arr_addr;
                    cyc(1'b0, 1'b0, 1'b0, ~base, 1'(m));
                    chk("R8 deselect active", AW'(active), '0);
                    chk("R8 deselect addr", arr_addr, held);
                    cyc(1'b0, 1'b1, 1'b1, ~base, 1'(m));
                    chk("R9 idle advance addr", arr_addr, held);
                    chk("R9 idle advance active", AW'(active), '0);
                end
            end
        end

        // R10: new order level applies at next load
        base = AW'(10'h2B1);
        cyc(1'b0, 1'b0, 1'b1, base, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b1);
        chk("R10 linear kept", arr_addr, {base[AW-1:2], 2'b11});
        cyc(1'b0, 1'b0, 1'b1, base, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b1);
        chk("R10 interleave at reload", arr_addr, {base[AW-1:2], 2'b11});
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b1);
        chk("R4 interleaved beat 3", arr_addr, {base[AW-1:2], 2'b10});

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule